// File: doc/BRIEF.md
# Single-Channel Block Copy DMA Engine

This block moves a block of bytes between a flash buffer window and system memory over one memory-side request/acknowledge master port. Software sets it up through a small bank of 32-bit registers: a source address and a destination address, a configuration word for each side, a byte count and a direction flag. It then writes the command register to start the copy and polls the status register until the done flag appears.

The two sides are set up independently. Each has its own beat width (8, 16 or 32 bits), its own burst code, and its own choice of incrementing or fixed addressing. The engine reads as many narrow beats as one wide beat needs and packs them little-endian into a staging word. It then writes that word out as destination beats. A typical read from flash uses 16-bit source beats and 32-bit destination beats. A write to flash uses the reverse pair.

When a transfer ends, the done flag is always set. The error flag is also set if the transfer was refused or aborted. Each flag stays set until its own command bit clears it.

Top module: `dma_xfer_engine`

## Requirements
- R1: The registers sit at these 12-bit offsets: source address 0x400, source config 0x404, destination address 0x408, destination config 0x40C, byte count 0x414, command 0x418, status 0x41C and direction 0x420. A read returns the value held one cycle after `reg_rd`. A config word reads back only bits [18:16] (burst code), bit 8 (fixed address) and bits [1:0] (width). Direction reads back bit 0 only.
- R2: Writing 1 to command bit 0 while the engine is idle starts a transfer, and status bit 17 (busy) reads 1 from the next cycle on. Busy falls in the same cycle that done rises.
- R3: The width codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit, driven on `mem_size`. For every pair of source and destination widths, the destination receives the source bytes in the same order. Narrow beats sit in the low bits of the data buses and are packed little-endian.
- R4: Config bit 8 set to 0 advances the address by the beat size after each beat. Set to 1, it keeps the address constant. A fixed source repeats the same beat. With a fixed destination, only the last beat written remains.
- R5: Each side's config bits [18:16] (0 single, 2 four-beat, 3 eight-beat, 4 sixteen-beat) appear on `mem_burst` during that side's accesses.
- R6: The transfer is refused if the byte count is zero, if it is not a multiple of the wider beat size, or if either width code is 3. A refused transfer sets status bit 16 (error) and bit 18 (done) and issues no memory access.
- R7: A memory response with `mem_err` high stops the transfer: no further beats are issued, and error and done are both set.
- R8: Done and error stay set until cleared. Writing command bit 18 clears only done, and writing command bit 16 clears only error.
- R9: A start command while busy is ignored. Writes to the address, config and count registers while busy do not change the transfer in progress.
- R10: The direction register value (0 flash to memory, 1 memory to flash) is driven on `mem_dir` for every access of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_dir | output | 1 | Direction of the current transfer |
| mem_addr | output | AW | Byte address of the beat |
| mem_size | output | 2 | Beat width code |
| mem_burst | output | 3 | Burst code of the accessed side |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_rdata | input | 32 | Read data, low-aligned, valid with ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Error response, valid with ack |

## Verification
The assertions assume that the memory side raises `mem_ack` only while a request is pending, and that it never acknowledges a beat that was not asked for. The bench's memory model serves a request only when it sees `mem_req` at a falling edge and holds ack for one cycle, so this assumption always holds. The assertions also assume that software issues no start command during reset. The bench issues commands only after reset, always through its own register tasks, and it sweeps every width pair and address mode with burst codes rotating across the transfers.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam logic [11:0] OFF_SRC_ADDR = 12'h400;
  localparam logic [11:0] OFF_SRC_CFG  = 12'h404;
  localparam logic [11:0] OFF_DST_ADDR = 12'h408;
  localparam logic [11:0] OFF_DST_CFG  = 12'h40C;
  localparam logic [11:0] OFF_COUNT    = 12'h414;
  localparam logic [11:0] OFF_CMD      = 12'h418;
  localparam logic [11:0] OFF_STATUS   = 12'h41C;
  localparam logic [11:0] OFF_DIR      = 12'h420;

  localparam int CMD_GO_BIT      = 0;
  localparam int CMD_CLR_ERR_BIT = 16;
  localparam int CMD_CLR_DONE_BIT = 18;

  typedef struct packed {
    logic [2:0] burst;
    logic       hold;
    logic [1:0] width;
  } side_cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_RD, S_WR} seq_state_t;

  function automatic side_cfg_t word_to_cfg(input logic [31:0] w);
    side_cfg_t c;
    c.burst = w[18:16];
    c.hold  = w[8];
    c.width = w[1:0];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input side_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[18:16] = c.burst;
    w[8]     = c.hold;
    w[1:0]   = c.width;
    return w;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] width);
    case (width)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              st_busy,
  input  logic              st_done,
  input  logic              st_err,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output side_cfg_t         src_cfg,
  output side_cfg_t         dst_cfg,
  output logic [SIZE_W-1:0] byte_count,
  output logic              xfer_dir,
  output logic              cmd_go,
  output logic              cmd_clr_err,
  output logic              cmd_clr_done
);
  logic wr_cmd;
  logic [31:0] status_word;

  assign wr_cmd       = reg_wr && (reg_addr == OFF_CMD);
  assign cmd_go       = wr_cmd && reg_wdata[CMD_GO_BIT];
  assign cmd_clr_err  = wr_cmd && reg_wdata[CMD_CLR_ERR_BIT];
  assign cmd_clr_done = wr_cmd && reg_wdata[CMD_CLR_DONE_BIT];

  always_comb begin
    status_word     = '0;
    status_word[18] = st_done;
    status_word[17] = st_busy;
    status_word[16] = st_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr   <= '0;
      dst_addr   <= '0;
      src_cfg    <= '0;
      dst_cfg    <= '0;
      byte_count <= '0;
      xfer_dir   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_SRC_ADDR: src_addr   <= reg_wdata[AW-1:0];
        OFF_DST_ADDR: dst_addr   <= reg_wdata[AW-1:0];
        OFF_SRC_CFG:  src_cfg    <= word_to_cfg(reg_wdata);
        OFF_DST_CFG:  dst_cfg    <= word_to_cfg(reg_wdata);
        OFF_COUNT:    byte_count <= reg_wdata[SIZE_W-1:0];
        OFF_DIR:      xfer_dir   <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFF_SRC_ADDR: reg_rdata <= 32'(src_addr);
        OFF_DST_ADDR: reg_rdata <= 32'(dst_addr);
        OFF_SRC_CFG:  reg_rdata <= cfg_to_word(src_cfg);
        OFF_DST_CFG:  reg_rdata <= cfg_to_word(dst_cfg);
        OFF_COUNT:    reg_rdata <= 32'(byte_count);
        OFF_STATUS:   reg_rdata <= status_word;
        OFF_DIR:      reg_rdata <= {31'd0, xfer_dir};
        default:      reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_clr_err,
  input  logic              cmd_clr_done,
  input  logic [AW-1:0]     cfg_src_addr,
  input  logic [AW-1:0]     cfg_dst_addr,
  input  side_cfg_t         cfg_src,
  input  side_cfg_t         cfg_dst,
  input  logic [SIZE_W-1:0] cfg_count,
  input  logic              cfg_dir,
  output logic              st_busy,
  output logic              st_done,
  output logic              st_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dir,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [2:0]        mem_burst,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  seq_state_t        state;
  side_cfg_t         scfg, dcfg;
  logic [AW-1:0]     saddr, daddr;
  logic [SIZE_W-1:0] remain;
  logic              dir_q;
  logic [1:0]        rd_idx, wr_idx;
  logic [31:0]       pbuf;

  logic [1:0]        lgw;
  logic [SIZE_W-1:0] chunk;
  logic [1:0]        rd_last, wr_last;
  logic [4:0]        rd_sh, wr_sh;
  logic              refuse;

  assign lgw     = (scfg.width > dcfg.width) ? scfg.width : dcfg.width;
  assign chunk   = SIZE_W'(1) << lgw;
  assign rd_last = 2'((3'd1 << (lgw - scfg.width)) - 3'd1);
  assign wr_last = 2'((3'd1 << (lgw - dcfg.width)) - 3'd1);
  assign rd_sh   = {rd_idx, 3'b000} << scfg.width;
  assign wr_sh   = {wr_idx, 3'b000} << dcfg.width;
  assign refuse  = (scfg.width == 2'd3) || (dcfg.width == 2'd3) ||
                   (remain == '0) || ((remain & (chunk - SIZE_W'(1))) != '0);

  assign st_busy   = (state != S_IDLE);
  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_dir   = dir_q;
  assign mem_addr  = mem_we ? daddr : saddr;
  assign mem_size  = mem_we ? dcfg.width : scfg.width;
  assign mem_burst = mem_we ? dcfg.burst : scfg.burst;
  assign mem_wdata = (pbuf >> wr_sh) & lane_mask(dcfg.width);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      st_done <= 1'b0;
      st_err  <= 1'b0;
      scfg    <= '0;
      dcfg    <= '0;
      saddr   <= '0;
      daddr   <= '0;
      remain  <= '0;
      dir_q   <= 1'b0;
      rd_idx  <= '0;
      wr_idx  <= '0;
      pbuf    <= '0;
    end else begin
      if (cmd_clr_err)  st_err  <= 1'b0;
      if (cmd_clr_done) st_done <= 1'b0;
      case (state)
        S_IDLE: if (cmd_go) begin
          scfg   <= cfg_src;
          dcfg   <= cfg_dst;
          saddr  <= cfg_src_addr;
          daddr  <= cfg_dst_addr;
          remain <= cfg_count;
          dir_q  <= cfg_dir;
          rd_idx <= '0;
          wr_idx <= '0;
          pbuf   <= '0;
          state  <= S_CHECK;
        end
        S_CHECK: if (refuse) begin
          state   <= S_IDLE;
          st_done <= 1'b1;
          st_err  <= 1'b1;
        end else begin
          state <= S_RD;
        end
        S_RD: if (mem_ack) begin
          if (mem_err) begin
            state   <= S_IDLE;
            st_done <= 1'b1;
            st_err  <= 1'b1;
          end else begin
            pbuf <= pbuf | ((mem_rdata & lane_mask(scfg.width)) << rd_sh);
            if (!scfg.hold) saddr <= saddr + (AW'(1) << scfg.width);
            if (rd_idx == rd_last) begin
              rd_idx <= '0;
              state  <= S_WR;
            end else begin
              rd_idx <= rd_idx + 2'd1;
            end
          end
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin
            state   <= S_IDLE;
            st_done <= 1'b1;
            st_err  <= 1'b1;
          end else begin
            if (!dcfg.hold) daddr <= daddr + (AW'(1) << dcfg.width);
            if (wr_idx == wr_last) begin
              wr_idx <= '0;
              pbuf   <= '0;
              if (remain == chunk) begin
                state   <= S_IDLE;
                st_done <= 1'b1;
              end else begin
                remain <= remain - chunk;
                state  <= S_RD;
              end
            end else begin
              wr_idx <= wr_idx + 2'd1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dir,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [2:0]    mem_burst,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err
);
  logic [AW-1:0]     src_addr_w, dst_addr_w;
  side_cfg_t         src_cfg_w, dst_cfg_w;
  logic [SIZE_W-1:0] count_w;
  logic              dir_w, go_w, clr_err_w, clr_done_w;
  logic              busy_w, done_w, err_w;

  dma_xfer_regs #(.AW(AW), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_busy(busy_w), .st_done(done_w), .st_err(err_w),
    .src_addr(src_addr_w), .dst_addr(dst_addr_w),
    .src_cfg(src_cfg_w), .dst_cfg(dst_cfg_w),
    .byte_count(count_w), .xfer_dir(dir_w),
    .cmd_go(go_w), .cmd_clr_err(clr_err_w), .cmd_clr_done(clr_done_w)
  );

  dma_xfer_seq #(.AW(AW), .SIZE_W(SIZE_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_go(go_w), .cmd_clr_err(clr_err_w),
    .cmd_clr_done(clr_done_w), .cfg_src_addr(src_addr_w),
    .cfg_dst_addr(dst_addr_w), .cfg_src(src_cfg_w), .cfg_dst(dst_cfg_w),
    .cfg_count(count_w), .cfg_dir(dir_w),
    .st_busy(busy_w), .st_done(done_w), .st_err(err_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dir(mem_dir),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_burst(mem_burst),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err)
  );
endmodule

// File: rtl/dma_xfer_checks.sv
module dma_xfer_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic          st_busy,
  input logic          st_done,
  input logic          st_err
);
  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> st_busy);

  assert_busy_falls_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(st_done) |-> $fell(st_busy));

  assert_width_legal_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 2'd3));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(st_err) |-> st_done);
endmodule

bind dma_xfer_engine dma_xfer_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
  .st_busy(busy_w), .st_done(done_w), .st_err(err_w)
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_dir;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [2:0] mem_burst;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0, mem_err = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mem [0:511];
  int access_cnt = 0, burst_bad = 0, dir_bad = 0;
  logic [2:0] exp_sburst = '0, exp_dburst = '0;
  logic exp_dir = 1'b0;
  logic err_en = 1'b0;
  logic [8:0] err_at = '0;

  dma_xfer_engine #(.AW(AW)) u_dma_xfer_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dir(mem_dir),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_burst(mem_burst),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // memory model: serves one pending request per falling edge, one-cycle ack
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req && !rst) begin
      access_cnt++;
      if (mem_burst != (mem_we ? exp_dburst : exp_sburst)) burst_bad++;
      if (mem_dir != exp_dir) dir_bad++;
      if (err_en && mem_addr[8:0] == err_at) begin
        mem_err = 1'b1;
      end else if (mem_we) begin
        for (int k = 0; k < (1 << mem_size); k++)
          mem[9'(mem_addr[8:0] + 9'(k))] = mem_wdata[8*k +: 8];
      end else begin
        for (int k = 0; k < 4; k++)
          mem_rdata[8*k +: 8] = mem[9'(mem_addr[8:0] + 9'(k))];
      end
      mem_ack = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int n = 0; n < 2000; n++) begin
      rd_reg(12'h41C, st);
      if (st[18]) break;
    end
  endtask

  function automatic logic [2:0] burst_code(input int i);
    case (i % 4)
      0: burst_code = 3'd0;
      1: burst_code = 3'd2;
      2: burst_code = 3'd3;
      default: burst_code = 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] src_pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = src_pat(i);
    for (int i = 256; i < 512; i++) mem[i] = 8'hEE;
  endtask

  task automatic setup(input int sw, input int dw, input int sh, input int dh,
                       input logic [2:0] sb, input logic [2:0] db, input int dir,
                       input int cnt, input int dst);
    exp_sburst = sb; exp_dburst = db; exp_dir = 1'(dir);
    wr_reg(12'h400, 32'h0);
    wr_reg(12'h408, 32'(dst));
    wr_reg(12'h404, {13'd0, sb, 7'd0, 1'(sh), 6'd0, 2'(sw)});
    wr_reg(12'h40C, {13'd0, db, 7'd0, 1'(dh), 6'd0, 2'(dw)});
    wr_reg(12'h414, 32'(cnt));
    wr_reg(12'h420, 32'(dir));
  endtask

  // expected byte j of the destination region after a good transfer
  function automatic logic [7:0] exp_byte(input int j, input int sw, input int dw,
                                          input int sh, input int dh, input int cnt);
    int sbytes, dbytes, i;
    sbytes = 1 << sw; dbytes = 1 << dw;
    if (dh != 0) begin
      if (j >= dbytes) return 8'hEE;
      i = cnt - dbytes + j;
    end else begin
      if (j >= cnt) return 8'hEE;
      i = j;
    end
    return (sh != 0) ? src_pat(i % sbytes) : src_pat(i);
  endfunction

  initial begin
    logic [31:0] d;
    int bad;
    int t;
    fill_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd_reg(12'h41C, d);
    chk(d == 32'h0 && !mem_req, "R8 reset status", d, 32'h0);

    // R1 register map and field masking
    wr_reg(12'h404, 32'hFFFF_FFFF);
    rd_reg(12'h404, d);
    chk(d == 32'h0007_0103, "R1 src cfg readback", d, 32'h0007_0103);
    wr_reg(12'h40C, 32'h0002_0001);
    rd_reg(12'h40C, d);
    chk(d == 32'h0002_0001, "R1 dst cfg readback", d, 32'h0002_0001);
    wr_reg(12'h400, 32'h1234_5678);
    rd_reg(12'h400, d);
    chk(d == 32'h1234_5678, "R1 src addr readback", d, 32'h1234_5678);
    wr_reg(12'h408, 32'h0BAD_F00D);
    rd_reg(12'h408, d);
    chk(d == 32'h0BAD_F00D, "R1 dst addr readback", d, 32'h0BAD_F00D);
    wr_reg(12'h420, 32'hFFFF_FFFF);
    rd_reg(12'h420, d);
    chk(d == 32'h1, "R1 dir readback", d, 32'h1);
    wr_reg(12'h414, 32'h0000_0040);
    rd_reg(12'h414, d);
    chk(d == 32'h40, "R1 count readback", d, 32'h40);

    // R3 R4 R5 R10 sweep of every width pair and address mode
    t = 0;
    for (int sw = 0; sw < 3; sw++)
      for (int dw = 0; dw < 3; dw++)
        for (int sh = 0; sh < 2; sh++)
          for (int dh = 0; dh < 2; dh++) begin
            fill_mem();
            burst_bad = 0; dir_bad = 0;
            setup(sw, dw, sh, dh, burst_code(t), burst_code(t + 1), t % 2, 16, 32'h100);
            wr_reg(12'h418, 32'h1);
            wait_done(d);
            chk(d[18:16] == 3'b100, "R2 sweep status done", d, 32'h0004_0000);
            bad = 0;
            for (int j = 0; j < 64; j++)
              if (mem[256 + j] !== exp_byte(j, sw, dw, sh, dh, 16)) bad++;
            chk(bad == 0, (sh || dh) ? "R4 addressing mode data" : "R3 width packing data",
                32'(bad), 32'h0);
            chk(burst_bad == 0, "R5 burst code", 32'(burst_bad), 32'h0);
            chk(dir_bad == 0, "R10 direction", 32'(dir_bad), 32'h0);
            wr_reg(12'h418, 32'h0004_0000);
            t++;
          end

    // R2 busy timing and R9 start while busy
    fill_mem();
    setup(0, 0, 0, 0, 3'd0, 3'd0, 0, 16, 32'h100);
    access_cnt = 0;
    wr_reg(12'h418, 32'h1);
    rd_reg(12'h41C, d);
    chk(d[18:16] == 3'b010, "R2 busy after start", d, 32'h0002_0000);
    wr_reg(12'h414, 32'h4);
    wr_reg(12'h408, 32'h180);
    wr_reg(12'h404, 32'h0000_0102);
    wr_reg(12'h418, 32'h1);
    wait_done(d);
    chk(d[18:16] == 3'b100, "R2 busy low with done", d, 32'h0004_0000);
    chk(access_cnt == 32, "R9 beats of original transfer", 32'(access_cnt), 32'd32);
    bad = 0;
    for (int j = 0; j < 16; j++) if (mem[256 + j] !== src_pat(j)) bad++;
    for (int j = 128; j < 256; j++) if (mem[256 + j] !== 8'hEE) bad++;
    chk(bad == 0, "R9 writes while busy ignored", 32'(bad), 32'h0);
    repeat (10) @(negedge clk);
    rd_reg(12'h41C, d);
    chk(d[17] == 1'b0, "R9 no second transfer", d, 32'h0004_0000);
    wr_reg(12'h418, 32'h0004_0000);

    // R6 refused transfers
    fill_mem();
    setup(1, 2, 0, 0, 3'd0, 3'd0, 0, 6, 32'h100);
    access_cnt = 0;
    wr_reg(12'h418, 32'h1);
    wait_done(d);
    chk(d[18:16] == 3'b101, "R6 odd count error", d, 32'h0005_0000);
    chk(access_cnt == 0, "R6 odd count no access", 32'(access_cnt), 32'h0);
    wr_reg(12'h418, 32'h0005_0000);
    setup(0, 0, 0, 0, 3'd0, 3'd0, 0, 0, 32'h100);
    wr_reg(12'h418, 32'h1);
    wait_done(d);
    chk(d[18:16] == 3'b101 && access_cnt == 0, "R6 zero count error", d, 32'h0005_0000);
    wr_reg(12'h418, 32'h0005_0000);
    setup(3, 0, 0, 0, 3'd0, 3'd0, 0, 8, 32'h100);
    wr_reg(12'h418, 32'h1);
    wait_done(d);
    chk(d[18:16] == 3'b101 && access_cnt == 0, "R6 width code 3 error", d, 32'h0005_0000);
    wr_reg(12'h418, 32'h0005_0000);

    // R7 memory error response aborts
    fill_mem();
    setup(2, 2, 0, 0, 3'd4, 3'd4, 1, 16, 32'h100);
    err_en = 1'b1; err_at = 9'h108;
    access_cnt = 0;
    wr_reg(12'h418, 32'h1);
    wait_done(d);
    err_en = 1'b0;
    chk(d[18:16] == 3'b101, "R7 error and done", d, 32'h0005_0000);
    chk(access_cnt == 6, "R7 no beats after error", 32'(access_cnt), 32'd6);
    bad = 0;
    for (int j = 0; j < 8; j++) if (mem[256 + j] !== src_pat(j)) bad++;
    for (int j = 8; j < 64; j++) if (mem[256 + j] !== 8'hEE) bad++;
    chk(bad == 0, "R7 partial data", 32'(bad), 32'h0);

    // R8 separate clearing
    wr_reg(12'h418, 32'h0001_0000);
    rd_reg(12'h41C, d);
    chk(d[18:16] == 3'b100, "R8 clear error only", d, 32'h0004_0000);
    repeat (5) @(negedge clk);
    rd_reg(12'h41C, d);
    chk(d[18:16] == 3'b100, "R8 done sticky", d, 32'h0004_0000);
    wr_reg(12'h418, 32'h0004_0000);
    rd_reg(12'h41C, d);
    chk(d[18:16] == 3'b000, "R8 clear done", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule